// File: doc/BRIEF.md
# String Load Execution Unit

This unit carries out one string-load instruction at a time. When an instruction is issued it forms the linear address from the data-segment base plus the source-index offset and checks it. A request goes to memory only if the access passes every check. The returned element is then written to the accumulator through byte enables, and the source index advances by the element size. If a check fails, the unit reports a fault code and commits nothing.

Two opcodes are accepted. `0xAC` always moves a single byte. `0xAD` moves a 16-, 32- or 64-bit element, chosen by the operand-size attribute. The surrounding pipeline keeps the architectural registers. It takes the write-back outputs when `doneValid` pulses and does not issue again while `busy` is high. The unit has no flags output because the instruction changes no arithmetic flag.

Top module: `strload_unit`

## Requirements
- R1: After reset, `busy`, `memReqValid` and `doneValid` are low.
- R2: Opcode 0xAC reads one byte. `memReqSize` is 0, `accWrData` is response bits 7:0 with zeros above, and `accByteEn` is 8'h01.
- R3: Opcode 0xAD uses `opSize` 0 for 16 bits (`accByteEn` 8'h03, data bits 15:0), 1 for 32 bits (`accByteEn` 8'hFF, data zero-extended from bits 31:0), and 2 or 3 for 64 bits (`accByteEn` 8'hFF). `memReqSize` is the log2 of the element bytes.
- R4: `srcIdxNext` is the source index plus the element size when `dirFlag` is 0, and minus it when `dirFlag` is 1, wrapping modulo 2^64.
- R5: `memReqAddr` is `segBase + srcIdx`. The request stays high with a stable address until `memReqReady` is seen. `doneValid` pulses for exactly one cycle, on the cycle after the accepted response.
- R6: If `srcIdx + bytes - 1` exceeds `segLimit`, the unit reports fault code 1 (general protection) and makes no memory request.
- R7: If the linear address is non-canonical (bits 63 down to VA_BITS-1 not all equal), the unit reports fault code 1 and makes no request.
- R8: A null segment with `protMode` high gives fault code 1. With `protMode` low the null status has no effect.
- R9: With `alignChkEn` high, a linear address that is not a multiple of the element size gives fault code 2 (alignment check). With `alignChkEn` low, misalignment has no effect.
- R10: A response that arrives with `memRspPageFault` high ends the instruction with fault code 3.
- R11: Any opcode other than 0xAC or 0xAD gives fault code 4 (invalid opcode) and makes no request.
- R12: On any fault (nonzero `faultCode` while `doneValid` is high), `accWrEn` and `srcIdxWrEn` are low. With no fault, both are high.
- R13: When several checks fail at once, the code reported follows this priority: invalid opcode, then general protection, then alignment check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Issue an instruction (taken when not busy) |
| opByte | input | 8 | Opcode byte |
| opSize | input | 2 | Operand size: 0=16, 1=32, 2/3=64 bits |
| dirFlag | input | 1 | 0 steps the index up, 1 steps it down |
| srcIdx | input | 64 | Source index offset |
| segBase | input | 64 | Data-segment base |
| segLimit | input | 64 | Data-segment limit (last valid offset) |
| segNull | input | 1 | Data segment is null |
| protMode | input | 1 | Protected mode enable |
| alignChkEn | input | 1 | Alignment checking enable |
| busy | output | 1 | Instruction in flight |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 64 | Linear read address |
| memReqSize | output | 2 | log2 of the element bytes |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 64 | Element, right-aligned |
| memRspPageFault | input | 1 | Access took a page fault |
| doneValid | output | 1 | Instruction complete (one cycle) |
| accWrEn | output | 1 | Write the accumulator |
| accWrData | output | 64 | Accumulator write data |
| accByteEn | output | 8 | Accumulator byte enables |
| srcIdxWrEn | output | 1 | Write the source index |
| srcIdxNext | output | 64 | Updated source index |
| faultCode | output | 3 | 0 none, 1 GP, 2 AC, 3 PF, 4 invalid opcode |

## Verification
The bench aims at the exact edge of the segment limit. There, a wide element that ends on the last valid offset must pass, and one byte more must fault; an off-by-one in the limit compare would either fault a legal access or let a stray one through. It steps the index downward from zero to catch a step that does not wrap. It also checks a 32-bit load whose response carries junk in the upper half, which catches a missing zero-extension. Cases with several faults at once show whether the priority order holds. Page-fault and null-in-real-mode cases show whether the unit wrongly commits state or wrongly raises a fault.

// File: rtl/strload_pkg.sv
package strload_pkg;
  localparam logic [7:0] OP_LOAD_BYTE = 8'hAC;
  localparam logic [7:0] OP_LOAD_WIDE = 8'hAD;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_GP   = 3'd1,
    FLT_AC   = 3'd2,
    FLT_PF   = 3'd3,
    FLT_UD   = 3'd4
  } fault_e;

  typedef struct packed {
    logic capture;
    logic latchFault;
    logic latchRsp;
  } strobe_t;
endpackage

// File: rtl/strload_ctrl.sv
module strload_ctrl
  import strload_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startValid,
  input  fault_e  chkFault,
  input  logic    memReqReady,
  input  logic    memRspValid,
  output strobe_t strobe,
  output logic    busy,
  output logic    memReqValid,
  output logic    doneValid
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_REQ, S_WAIT, S_DONE} state_e;
  state_e state, stateNext;

  always_comb begin
    strobe.capture    = (state == S_IDLE) && startValid;
    strobe.latchFault = (state == S_CHECK) && (chkFault != FLT_NONE);
    strobe.latchRsp   = (state == S_WAIT) && memRspValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (startValid) stateNext = S_CHECK;
      S_CHECK: stateNext = (chkFault != FLT_NONE) ? S_DONE : S_REQ;
      S_REQ:   if (memReqReady) stateNext = S_WAIT;
      S_WAIT:  if (memRspValid) stateNext = S_DONE;
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy        = (state != S_IDLE);
  assign memReqValid = (state == S_REQ);
  assign doneValid   = (state == S_DONE);
endmodule

// File: rtl/strload_dp.sv
module strload_dp
  import strload_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [7:0]        opByte,
  input  logic [1:0]        opSize,
  input  logic              dirFlag,
  input  logic [ADDR_W-1:0] srcIdx,
  input  logic [ADDR_W-1:0] segBase,
  input  logic [ADDR_W-1:0] segLimit,
  input  logic              segNull,
  input  logic              protMode,
  input  logic              alignChkEn,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              memRspPageFault,
  output fault_e            chkFault,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [1:0]        memReqSize,
  output fault_e            resFault,
  output logic [DATA_W-1:0] resData,
  output logic [DATA_W/8-1:0] resByteEn,
  output logic [ADDR_W-1:0] resSrcNext
);
  localparam int BE_W   = DATA_W / 8;
  localparam int CANO_W = ADDR_W - VA_BITS + 1;

  logic              opOk, opWide, dirQ, nullQ, protQ, alignQ;
  logic [1:0]        sizeLogQ;
  logic [ADDR_W-1:0] idxQ, baseQ, limitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opOk <= 1'b0; opWide <= 1'b0; dirQ <= 1'b0; nullQ <= 1'b0;
      protQ <= 1'b0; alignQ <= 1'b0; sizeLogQ <= 2'd0;
      idxQ <= '0; baseQ <= '0; limitQ <= '0;
    end else if (strobe.capture) begin
      opOk   <= (opByte == OP_LOAD_BYTE) || (opByte == OP_LOAD_WIDE);
      opWide <= (opByte == OP_LOAD_WIDE);
      if (opByte == OP_LOAD_WIDE) begin
        unique case (opSize)
          2'd0:    sizeLogQ <= 2'd1;
          2'd1:    sizeLogQ <= 2'd2;
          default: sizeLogQ <= 2'd3;
        endcase
      end else begin
        sizeLogQ <= 2'd0;
      end
      dirQ   <= dirFlag;
      idxQ   <= srcIdx;
      baseQ  <= segBase;
      limitQ <= segLimit;
      nullQ  <= segNull;
      protQ  <= protMode;
      alignQ <= alignChkEn;
    end
  end

  logic [ADDR_W-1:0] elemBytes, linAddr, stepIdx;
  logic [ADDR_W:0]   lastOff;
  logic [CANO_W-1:0] canoBits;
  logic              limitBad, canoBad, nullBad, alignBad;

  always_comb begin
    elemBytes = ADDR_W'(1) << sizeLogQ;
    linAddr   = baseQ + idxQ;
    lastOff   = {1'b0, idxQ} + {1'b0, elemBytes} - (ADDR_W+1)'(1);
    limitBad  = lastOff > {1'b0, limitQ};
    canoBits  = linAddr[ADDR_W-1:VA_BITS-1];
    canoBad   = !((&canoBits) || !(|canoBits));
    nullBad   = protQ && nullQ;
    alignBad  = alignQ && ((linAddr & (elemBytes - ADDR_W'(1))) != '0);
    stepIdx   = dirQ ? (idxQ - elemBytes) : (idxQ + elemBytes);
    if (!opOk)                             chkFault = FLT_UD;
    else if (nullBad || limitBad || canoBad) chkFault = FLT_GP;
    else if (alignBad)                     chkFault = FLT_AC;
    else                                   chkFault = FLT_NONE;
  end

  assign memReqAddr = linAddr;
  assign memReqSize = sizeLogQ;

  logic [DATA_W-1:0] shapedData;
  logic [BE_W-1:0]   shapedEn;

  always_comb begin
    shapedData = '0;
    shapedEn   = '0;
    unique case (sizeLogQ)
      2'd0: begin shapedData[7:0]  = memRspData[7:0];  shapedEn[0]   = 1'b1;  end
      2'd1: begin shapedData[15:0] = memRspData[15:0]; shapedEn[1:0] = 2'b11; end
      2'd2: begin shapedData[31:0] = memRspData[31:0]; shapedEn      = '1;    end
      default: begin shapedData    = memRspData;       shapedEn      = '1;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resFault <= FLT_NONE; resData <= '0; resByteEn <= '0; resSrcNext <= '0;
    end else if (strobe.latchFault) begin
      resFault <= chkFault; resData <= '0; resByteEn <= '0; resSrcNext <= idxQ;
    end else if (strobe.latchRsp) begin
      if (memRspPageFault) begin
        resFault <= FLT_PF; resData <= '0; resByteEn <= '0; resSrcNext <= idxQ;
      end else begin
        resFault <= FLT_NONE; resData <= shapedData; resByteEn <= shapedEn;
        resSrcNext <= stepIdx;
      end
    end
  end

  logic unusedWide;
  assign unusedWide = opWide;
endmodule

// File: rtl/strload_unit.sv
module strload_unit
  import strload_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  input  logic [7:0]          opByte,
  input  logic [1:0]          opSize,
  input  logic                dirFlag,
  input  logic [ADDR_W-1:0]   srcIdx,
  input  logic [ADDR_W-1:0]   segBase,
  input  logic [ADDR_W-1:0]   segLimit,
  input  logic                segNull,
  input  logic                protMode,
  input  logic                alignChkEn,
  output logic                busy,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [1:0]          memReqSize,
  input  logic                memRspValid,
  input  logic [DATA_W-1:0]   memRspData,
  input  logic                memRspPageFault,
  output logic                doneValid,
  output logic                accWrEn,
  output logic [DATA_W-1:0]   accWrData,
  output logic [DATA_W/8-1:0] accByteEn,
  output logic                srcIdxWrEn,
  output logic [ADDR_W-1:0]   srcIdxNext,
  output logic [2:0]          faultCode
);
  strobe_t strobe;
  fault_e  chkFault, resFault;

  strload_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .chkFault(chkFault),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .strobe(strobe),
    .busy(busy), .memReqValid(memReqValid), .doneValid(doneValid)
  );

  strload_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opByte(opByte), .opSize(opSize),
    .dirFlag(dirFlag), .srcIdx(srcIdx), .segBase(segBase), .segLimit(segLimit),
    .segNull(segNull), .protMode(protMode), .alignChkEn(alignChkEn),
    .memRspData(memRspData), .memRspPageFault(memRspPageFault),
    .chkFault(chkFault), .memReqAddr(memReqAddr), .memReqSize(memReqSize),
    .resFault(resFault), .resData(accWrData), .resByteEn(accByteEn),
    .resSrcNext(srcIdxNext)
  );

  assign faultCode  = doneValid ? 3'(resFault) : 3'd0;
  assign accWrEn    = doneValid && (resFault == FLT_NONE);
  assign srcIdxWrEn = doneValid && (resFault == FLT_NONE);
endmodule

// File: rtl/strload_chk.sv
module strload_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                busy,
  input logic                memReqValid,
  input logic                memReqReady,
  input logic [ADDR_W-1:0]   memReqAddr,
  input logic                doneValid,
  input logic                accWrEn,
  input logic [DATA_W-1:0]   accWrData,
  input logic [DATA_W/8-1:0] accByteEn,
  input logic                srcIdxWrEn,
  input logic [2:0]          faultCode
);
  // R5: a pending request holds with a stable address
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));
  // R5: completion pulses for one cycle only
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R12: a fault blocks both write-backs
  p_no_commit_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && (faultCode != 3'd0) |-> !accWrEn && !srcIdxWrEn);
  // R12: a clean finish writes both
  p_commit_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && (faultCode == 3'd0) |-> accWrEn && srcIdxWrEn);
  // R2: a byte write clears the bits above the low byte
  p_byte_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    accWrEn && (accByteEn == 8'h01) |-> (accWrData[DATA_W-1:8] == '0));
  // R3: enables take one of the legal shapes
  p_be_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    accWrEn |-> (accByteEn == 8'h01) || (accByteEn == 8'h03) || (accByteEn == 8'hFF));
  // R1: request and completion only while busy
  p_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || doneValid) |-> busy);
endmodule

bind strload_unit strload_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .doneValid(doneValid),
  .accWrEn(accWrEn), .accWrData(accWrData), .accByteEn(accByteEn),
  .srcIdxWrEn(srcIdxWrEn), .faultCode(faultCode)
);

// File: tb/test_strload_unit.sv
module test_strload_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [7:0] opByte = 8'h0;
  logic [1:0] opSize = 2'd0;
  logic dirFlag = 1'b0;
  logic [63:0] srcIdx = '0, segBase = '0, segLimit = '0;
  logic segNull = 1'b0, protMode = 1'b0, alignChkEn = 1'b0;
  logic busy, memReqValid, memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic [1:0] memReqSize;
  logic memRspValid = 1'b0, memRspPageFault = 1'b0;
  logic [63:0] memRspData = '0;
  logic doneValid, accWrEn, srcIdxWrEn;
  logic [63:0] accWrData, srcIdxNext;
  logic [7:0] accByteEn;
  logic [2:0] faultCode;

  int errors = 0;
  int checks = 0;
  int doneSeen = 0;

  always #4ns clk = ~clk;

  strload_unit i_strload_unit (.*);

  typedef struct {
    logic [2:0]  fault;
    logic [63:0] data;
    logic [7:0]  be;
    logic [63:0] next;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected item on each completion
  always @(negedge clk) begin
    if (rstN && doneValid) begin
      doneSeen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected completion", 64'(faultCode), 64'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(faultCode == e.fault, e.tag, "faultCode", 64'(faultCode), 64'(e.fault));
        if (e.fault == 3'd0) begin
          check(accWrEn && srcIdxWrEn, e.tag, "write enables", {62'h0, accWrEn, srcIdxWrEn}, 64'h3);
          check(accWrData == e.data, e.tag, "accWrData", accWrData, e.data);
          check(accByteEn == e.be, e.tag, "accByteEn", 64'(accByteEn), 64'(e.be));
          check(srcIdxNext == e.next, e.tag, "srcIdxNext", srcIdxNext, e.next);
        end else begin
          check(!accWrEn && !srcIdxWrEn, "R12", "writes on fault", {62'h0, accWrEn, srcIdxWrEn}, 64'h0);
        end
      end
    end
  end

  // driver: issue, serve memory, push expectation
  task automatic runOp(input string tag, input logic [7:0] op, input logic [1:0] sz,
                       input logic dir, input logic [63:0] si, input logic [63:0] base,
                       input logic [63:0] lim, input logic nul, input logic prot,
                       input logic ac, input logic [63:0] rsp, input logic pf,
                       input logic [2:0] expFault, input int stall);
    exp_t e;
    int bytes;
    int lg;
    bit expReq;
    bit reqSeen;
    int startDone;
    lg = (op == 8'hAC) ? 0 : (sz == 2'd0 ? 1 : (sz == 2'd1 ? 2 : 3));
    bytes = 1 << lg;
    expReq = (expFault == 3'd0) || (expFault == 3'd3);
    e.fault = expFault;
    e.tag = tag;
    e.be = (lg == 0) ? 8'h01 : (lg == 1 ? 8'h03 : 8'hFF);
    e.data = (lg == 0) ? {56'h0, rsp[7:0]} : (lg == 1 ? {48'h0, rsp[15:0]} :
             (lg == 2 ? {32'h0, rsp[31:0]} : rsp));
    e.next = dir ? si - 64'(bytes) : si + 64'(bytes);
    expQ.push_back(e);
    startDone = doneSeen;
    reqSeen = 1'b0;
    @(negedge clk);
    opByte = op; opSize = sz; dirFlag = dir; srcIdx = si; segBase = base;
    segLimit = lim; segNull = nul; protMode = prot; alignChkEn = ac;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    for (int i = 0; i < 40 && doneSeen == startDone; i++) begin
      if (memReqValid && !reqSeen) begin
        reqSeen = 1'b1;
        check(memReqAddr == base + si, "R5", "memReqAddr", memReqAddr, base + si);
        check(memReqSize == 2'(lg), tag, "memReqSize", 64'(memReqSize), 64'(lg));
        for (int s = 0; s < stall; s++) @(negedge clk);
        if (stall > 0)
          check(memReqValid && memReqAddr == base + si, "R5", "held request", memReqAddr, base + si);
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        memRspValid = 1'b1; memRspData = rsp; memRspPageFault = pf;
        @(negedge clk);
        memRspValid = 1'b0; memRspPageFault = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check(reqSeen == expReq, tag, "request issued", 64'(reqSeen), 64'(expReq));
    check(doneSeen == startDone + 1, tag, "completion count", 64'(doneSeen - startDone), 64'h1);
    @(negedge clk);
  endtask

  localparam logic [63:0] MAXL = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !memReqValid && !doneValid, "R1", "reset outputs",
          {61'h0, busy, memReqValid, doneValid}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReqValid && !doneValid, "R1", "idle after reset",
          {61'h0, busy, memReqValid, doneValid}, 64'h0);
    // R2 byte load, step up (R4)
    runOp("R2", 8'hAC, 2'd2, 0, 64'h100, 64'h1000, MAXL, 0, 1, 1, 64'h1122_3344_5566_77EF, 0, 3'd0, 0);
    // R3 word, step down (R4)
    runOp("R3", 8'hAD, 2'd0, 1, 64'h200, 64'h0, MAXL, 0, 1, 1, 64'hAAAA_BBBB_CCCC_1234, 0, 3'd0, 0);
    // R3 dword zero-extends
    runOp("R3", 8'hAD, 2'd1, 0, 64'h40, 64'h0, MAXL, 0, 1, 1, 64'hFFFF_FFFF_1234_5678, 0, 3'd0, 0);
    // R5 qword with held request; opSize 3 also 64-bit (R3)
    runOp("R5", 8'hAD, 2'd2, 0, 64'h80, 64'h8, MAXL, 0, 1, 0, 64'h0123_4567_89AB_CDEF, 0, 3'd0, 3);
    runOp("R3", 8'hAD, 2'd3, 1, 64'h88, 64'h0, MAXL, 0, 1, 0, 64'hFEDC_BA98_7654_3210, 0, 3'd0, 1);
    // R4 wrap below zero
    runOp("R4", 8'hAC, 2'd0, 1, 64'h0, 64'h5000, MAXL, 0, 0, 0, 64'h5A, 0, 3'd0, 0);
    // R6 limit edge
    runOp("R6", 8'hAD, 2'd0, 0, 64'hFE, 64'h0, 64'hFF, 0, 1, 0, 64'hBEEF, 0, 3'd0, 0);
    runOp("R6", 8'hAD, 2'd1, 0, 64'hFE, 64'h0, 64'hFF, 0, 1, 0, 64'h0, 0, 3'd1, 0);
    runOp("R6", 8'hAC, 2'd0, 0, 64'h100, 64'h0, 64'hFF, 0, 1, 0, 64'h0, 0, 3'd1, 0);
    // R7 non-canonical
    runOp("R7", 8'hAC, 2'd0, 0, 64'h0, 64'h0000_8000_0000_0000, MAXL, 0, 1, 0, 64'h0, 0, 3'd1, 0);
    runOp("R7", 8'hAC, 2'd0, 0, 64'h0, 64'hFFFF_8000_0000_0000, MAXL, 0, 1, 0, 64'h77, 0, 3'd0, 0);
    // R8 null segment
    runOp("R8", 8'hAC, 2'd0, 0, 64'h10, 64'h0, MAXL, 1, 1, 0, 64'h0, 0, 3'd1, 0);
    runOp("R8", 8'hAC, 2'd0, 0, 64'h10, 64'h0, MAXL, 1, 0, 0, 64'h3C, 0, 3'd0, 0);
    // R9 alignment
    runOp("R9", 8'hAD, 2'd1, 0, 64'h1, 64'h0, MAXL, 0, 1, 1, 64'h0, 0, 3'd2, 0);
    runOp("R9", 8'hAD, 2'd1, 0, 64'h1, 64'h0, MAXL, 0, 1, 0, 64'h9999_0000_CAFE_F00D, 0, 3'd0, 0);
    runOp("R9", 8'hAC, 2'd0, 0, 64'h3, 64'h0, MAXL, 0, 1, 1, 64'h11, 0, 3'd0, 0);
    // R10 page fault
    runOp("R10", 8'hAD, 2'd2, 0, 64'h100, 64'h0, MAXL, 0, 1, 0, 64'hDEAD, 1, 3'd3, 0);
    // R11 invalid opcode
    runOp("R11", 8'h90, 2'd0, 0, 64'h0, 64'h0, MAXL, 0, 1, 0, 64'h0, 0, 3'd4, 0);
    // R13 priority
    runOp("R13", 8'hAE, 2'd0, 0, 64'h1, 64'h0, 64'h0, 1, 1, 1, 64'h0, 0, 3'd4, 0);
    runOp("R13", 8'hAD, 2'd1, 0, 64'h1, 64'h0, MAXL, 1, 1, 1, 64'h0, 0, 3'd1, 0);
    check(expQ.size() == 0, "R5", "pending expectations", 64'(expQ.size()), 64'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8ns * 200000);
    errors++;
    checks++;
    $display("FAIL R5 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule